// File: doc/BRIEF.md
# Open-Row Parking SDRAM Command Sequencer

This block sits between a single host and an SDRAM device. After each access it leaves the row it used open in its bank. One tracking register holds that bank and row, together with a flag that says whether the bank is really open. Every new request is compared against the register and sorted into one of four cases:

- **hit**: the same row of the open bank.
- **empty**: nothing is open.
- **bank miss**: a different bank.
- **row miss**: the same bank but another row.

Each case gets its own shortest command sequence on the SDRAM command bus. On a bank miss, the activate of the new bank goes out first. The precharge that closes the old bank follows in the very next cycle, so the two latencies overlap.

The host offers a request with bank, row, column and direction. The request is taken on a valid/ready handshake. The read or write command on the bus is the point at which the request has been served.

A refresh timer forces a refresh well inside the configured period. Before the refresh, the sequencer closes any open bank. After the refresh, the tracking flag is clear, so the next request starts with an activate. Per-bank precharge-to-activate spacing, activate-to-column spacing and refresh recovery are all counted in clock cycles set by parameters.

Top module: `sdram_openrow_ctrl`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle and no refresh is pending. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. In every cycle where `req_ready` is high, `cmd` is NOP. Out of reset, `req_ready` is 1 and `cmd` is NOP.
- R2: The `cmd` encoding is NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, and no other code appears. For ACT, `cmd_addr` carries the row, zero-extended. For RD and WR, it carries the column, zero-extended. `cmd_bank` names the bank for ACT, PRE, RD and WR.
- R3: Hit (flag set, same bank, same row): RD or WR is issued in the cycle right after the request is taken, with no ACT.
- R4: Empty (flag clear, as after reset or after a refresh): ACT to the requested bank and row is issued in the first legal cycle at or after the cycle following acceptance. The column command follows exactly T_RCD cycles after the ACT.
- R5: Bank miss (flag set, different bank): ACT to the new bank is issued in the first legal cycle. PRE to the previously open bank follows in the next cycle. The column command comes T_RCD cycles after the ACT, with T_RCD treated as at least 2.
- R6: Row miss (flag set, same bank, different row): PRE to that bank is issued in the cycle after acceptance. ACT to the new row follows T_RP cycles after the PRE, and the column command follows T_RCD cycles after the ACT.
- R7: An ACT to a bank is never less than T_RP cycles after the last PRE to that bank. A REF is never less than T_RP cycles after any PRE.
- R8: RD and WR go only to the bank and row that are currently open. The tracking register then holds that bank and row with its flag set.
- R9: REF is issued only with every bank closed; an open bank is precharged first. REF clears the tracking flag. No ACT follows within T_RFC cycles of a REF. Successive REFs, and the first REF after reset, are never more than REF_PERIOD cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Requested bank |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| cmd | output | 3 | SDRAM command code |
| cmd_bank | output | BANK_W | Bank the command addresses |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column for the command |

## Verification
The hardest case to reach is a bank miss that must stall because its target bank was closed only a few cycles earlier by the overlapped precharge of a previous bank miss. Reaching it also requires the refresh timer to fire at arbitrary points within such a sequence.

The bench sweeps every ordered pair of (bank, row) targets in a four-bank, four-row configuration, so every transition class follows every other. It uses a precharge spacing longer than the shortest round trip, so back-and-forth bank misses do stall. The refresh period is short enough that refreshes land between many of the pairs.

The expected command times are computed from the bench's own record of bank state and precharge times.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } sdc_cmd_e;

    typedef enum logic [1:0] {
        CLS_HIT,
        CLS_EMPTY,
        CLS_BANK_MISS,
        CLS_ROW_MISS
    } sdc_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_PRE_OLD,
        ST_RCD,
        ST_REF,
        ST_RFC
    } sdc_state_e;

    // Sort a request against the parked bank/row.
    function automatic sdc_cls_e classify(input logic vld, input logic bank_eq,
                                          input logic row_eq);
        if (!vld)          return CLS_EMPTY;
        else if (!bank_eq) return CLS_BANK_MISS;
        else if (!row_eq)  return CLS_ROW_MISS;
        return CLS_HIT;
    endfunction

endpackage

// File: rtl/sdc_row_tracker.sv
module sdc_row_tracker
    import sdc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              close_en,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic              open_valid,
    output logic [BANK_W-1:0] open_bank,
    output logic [ROW_W-1:0]  open_row,
    output logic [BANK_W-1:0] prev_bank,
    output sdc_cls_e          cls
);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_valid <= 1'b0;
            open_bank  <= '0;
            open_row   <= '0;
            prev_bank  <= '0;
        end else if (set_en) begin
            open_valid <= 1'b1;
            prev_bank  <= open_bank;
            open_bank  <= set_bank;
            open_row   <= set_row;
        end else if (close_en) begin
            open_valid <= 1'b0;
        end
    end

    assign cls = classify(open_valid, req_bank == open_bank, req_row == open_row);

    // R8
    set_loads_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> (open_valid && open_bank == $past(set_bank) && open_row == $past(set_row)));

    // R9
    close_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (close_en && !set_en) |=> !open_valid);

endmodule

// File: rtl/sdc_bank_rp_timer.sv
module sdc_bank_rp_timer #(
    parameter int BANK_W = 2,
    parameter int T_RP   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pre_en,
    input  logic [BANK_W-1:0]        pre_bank,
    output logic [(1<<BANK_W)-1:0]   busy
);

    localparam int NB = 1 << BANK_W;
    localparam int CW = $clog2(T_RP + 1);

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [CW-1:0] left;
        always_ff @(posedge clk) begin
            if (rst)
                left <= '0;
            else if (pre_en && pre_bank == BANK_W'(g))
                left <= CW'(T_RP - 1);
            else if (left != '0)
                left <= left - 1'b1;
        end
        assign busy[g] = (left != '0);
    end

endmodule

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
    parameter int REF_PERIOD = 1950,
    parameter int MARGIN     = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_done,
    output logic pend
);

    localparam int CW  = $clog2(REF_PERIOD + 1);
    localparam int LIM = REF_PERIOD - MARGIN;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ref_done)
            cnt <= '0;
        else if (cnt != CW'(REF_PERIOD))
            cnt <= cnt + 1'b1;
    end

    assign pend = (cnt >= CW'(LIM));

    // R9
    ref_overdue_chk: assert property (@(posedge clk) disable iff (rst)
        cnt != CW'(REF_PERIOD));

endmodule

// File: rtl/sdram_openrow_ctrl.sv
module sdram_openrow_ctrl
    import sdc_pkg::*;
#(
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 12,
    parameter int COL_W      = 8,
    parameter int T_RP       = 3,
    parameter int T_RCD      = 3,
    parameter int T_RFC      = 8,
    parameter int REF_PERIOD = 1950,
    localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr
);

    localparam int NB      = 1 << BANK_W;
    localparam int RCD_EFF = (T_RCD < 2) ? 2 : T_RCD;
    localparam int WMAX    = (RCD_EFF > T_RFC) ? RCD_EFF : T_RFC;
    localparam int WCW     = $clog2(WMAX + 1);
    localparam int MARGIN  = 3 * T_RP + 2 * RCD_EFF + T_RFC + 8;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        sdc_cls_e          cls;
    } req_t;

    sdc_state_e        state, state_n;
    req_t              cur;
    logic              for_ref;
    logic [WCW-1:0]    wcnt;
    logic [NB-1:0]     rp_busy;
    logic              ref_pend;
    sdc_cls_e          in_cls;
    logic              open_valid;
    logic [BANK_W-1:0] open_bank, prev_bank;
    logic [ROW_W-1:0]  open_row;
    sdc_cmd_e          cmd_e;
    logic              act_go, pre_go, ref_go, accept, close_en;

    assign req_ready = (state == ST_IDLE) && !ref_pend;
    assign accept    = req_valid && req_ready;
    assign close_en  = (pre_go && state == ST_PRE) || ref_go;

    sdc_row_tracker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_track (
        .clk(clk), .rst(rst),
        .set_en(act_go), .set_bank(cur.bank), .set_row(cur.row),
        .close_en(close_en),
        .req_bank(req_bank), .req_row(req_row),
        .open_valid(open_valid), .open_bank(open_bank), .open_row(open_row),
        .prev_bank(prev_bank), .cls(in_cls)
    );

    sdc_bank_rp_timer #(.BANK_W(BANK_W), .T_RP(T_RP)) u_rp (
        .clk(clk), .rst(rst), .pre_en(pre_go), .pre_bank(cmd_bank), .busy(rp_busy)
    );

    sdc_refresh_timer #(.REF_PERIOD(REF_PERIOD), .MARGIN(MARGIN)) u_ref (
        .clk(clk), .rst(rst), .ref_done(ref_go), .pend(ref_pend)
    );

    always_comb begin
        state_n  = state;
        cmd_e    = CMD_NOP;
        cmd_bank = '0;
        cmd_addr = '0;
        act_go   = 1'b0;
        pre_go   = 1'b0;
        ref_go   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend)
                    state_n = open_valid ? ST_PRE : ST_REF;
                else if (req_valid) begin
                    unique case (in_cls)
                        CLS_HIT:      state_n = ST_RCD;
                        CLS_ROW_MISS: state_n = ST_PRE;
                        default:      state_n = ST_ACT;
                    endcase
                end
            end
            ST_PRE: begin
                cmd_e    = CMD_PRE;
                cmd_bank = open_bank;
                pre_go   = 1'b1;
                state_n  = for_ref ? ST_REF : ST_ACT;
            end
            ST_ACT: begin
                if (!rp_busy[cur.bank]) begin
                    cmd_e    = CMD_ACT;
                    cmd_bank = cur.bank;
                    cmd_addr = ADDR_W'(cur.row);
                    act_go   = 1'b1;
                    state_n  = (cur.cls == CLS_BANK_MISS) ? ST_PRE_OLD : ST_RCD;
                end
            end
            ST_PRE_OLD: begin
                cmd_e    = CMD_PRE;
                cmd_bank = prev_bank;
                pre_go   = 1'b1;
                state_n  = ST_RCD;
            end
            ST_RCD: begin
                if (wcnt == '0) begin
                    cmd_e    = cur.wr ? CMD_WR : CMD_RD;
                    cmd_bank = cur.bank;
                    cmd_addr = ADDR_W'(cur.col);
                    state_n  = ST_IDLE;
                end
            end
            ST_REF: begin
                if (rp_busy == '0) begin
                    cmd_e   = CMD_REF;
                    ref_go  = 1'b1;
                    state_n = ST_RFC;
                end
            end
            ST_RFC: begin
                if (wcnt == '0) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign cmd = cmd_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur     <= '0;
            for_ref <= 1'b0;
            wcnt    <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                cur     <= '{bank: req_bank, row: req_row, col: req_col,
                             wr: req_write, cls: in_cls};
                for_ref <= 1'b0;
                wcnt    <= '0;
            end else if (state == ST_IDLE && ref_pend) begin
                for_ref <= 1'b1;
            end else if (act_go) begin
                wcnt <= WCW'(RCD_EFF - 1);
            end else if (ref_go) begin
                wcnt <= WCW'(T_RFC - 1);
            end else if (wcnt != '0) begin
                wcnt <= wcnt - 1'b1;
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cmd == 3'd0);

    // R5
    bank_miss_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_e == CMD_ACT && cur.cls == CLS_BANK_MISS)
            |=> (cmd_e == CMD_PRE && cmd_bank != $past(cmd_bank)));

    // R8
    col_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_e == CMD_RD || cmd_e == CMD_WR)
            |-> (open_valid && open_bank == cmd_bank && open_row == cur.row));

    // R9
    ref_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_e == CMD_REF) |-> (!open_valid && rp_busy == '0));

    // R7
    act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_e == CMD_PRE) |=> !(cmd_e == CMD_ACT && cmd_bank == $past(cmd_bank) && T_RP > 1));

endmodule

// File: tb/sdram_openrow_ctrl_tb.sv
module sdram_openrow_ctrl_tb;

    localparam int BANK_W = 2, ROW_W = 2, COL_W = 3;
    localparam int T_RP = 5, T_RCD = 3, T_RFC = 5, REF_PERIOD = 150;
    localparam int ADDR_W = 3;
    localparam int NB = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [2:0]        cmd;
    logic [BANK_W-1:0] cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;

    int errors = 0, checks = 0, cyc = 0;

    // bench model
    int  last_pre [NB];
    int  act_cyc  [NB];
    bit  bopen    [NB];
    int  last_pre_any = -1000, last_ref = 0;
    bit  ref_seen = 0;
    bit  exp_valid = 0;
    int  exp_bank = 0, exp_row = 0;

    sdram_openrow_ctrl #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP),
        .T_RCD(T_RCD), .T_RFC(T_RFC), .REF_PERIOD(REF_PERIOD)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr));

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) if (cyc > 150000) begin
        check(0, "watchdog", cyc, 150000);
        finish_run();
    end

    // protocol monitor
    always @(negedge clk) if (!rst) begin
        case (cmd)
            3'd0: ;
            3'd1: begin
                check(!bopen[cmd_bank], "R7 ACT to closed bank", int'(bopen[cmd_bank]), 0);
                check(cyc - last_pre[cmd_bank] >= T_RP, "R7 ACT after PRE gap",
                      cyc - last_pre[cmd_bank], T_RP);
                if (ref_seen)
                    check(cyc - last_ref >= T_RFC, "R9 ACT after REF gap", cyc - last_ref, T_RFC);
                bopen[cmd_bank]   = 1;
                act_cyc[cmd_bank] = cyc;
            end
            3'd2, 3'd3: begin
                check(bopen[cmd_bank], "R8 column to open bank", int'(bopen[cmd_bank]), 1);
                check(cyc - act_cyc[cmd_bank] >= T_RCD, "R8 column after ACT gap",
                      cyc - act_cyc[cmd_bank], T_RCD);
            end
            3'd4: begin
                check(bopen[cmd_bank], "R7 PRE to open bank", int'(bopen[cmd_bank]), 1);
                bopen[cmd_bank]    = 0;
                last_pre[cmd_bank] = cyc;
                last_pre_any       = cyc;
            end
            3'd5: begin
                int nopen = 0;
                for (int i = 0; i < NB; i++) nopen += int'(bopen[i]);
                check(nopen == 0, "R9 REF with banks closed", nopen, 0);
                check(cyc - last_pre_any >= T_RP, "R7 REF after PRE gap", cyc - last_pre_any, T_RP);
                check(cyc - last_ref <= REF_PERIOD, "R9 refresh gap", cyc - last_ref, REF_PERIOD);
                last_ref  = cyc;
                ref_seen  = 1;
                exp_valid = 0;
            end
            default: check(0, "R2 illegal code", int'(cmd), 0);
        endcase
    end

    task automatic issue(input int b, input int r, input int c, input bit w);
        int a, x, n_exp, n_obs, cls_pre_b;
        int e_cmd[3], e_bank[3], e_addr[3], e_cyc[3];
        string tag;
        bit ready_leak = 0, done = 0;
        req_valid = 1; req_bank = BANK_W'(b); req_row = ROW_W'(r);
        req_col = COL_W'(c); req_write = w;
        while (!req_ready) begin @(negedge clk); #1; end
        a = cyc;
        n_exp = 0;
        if (exp_valid && exp_bank == b && exp_row == r) begin
            tag = "R3 hit";
        end else if (!exp_valid) begin
            tag = "R4 empty";
            x = (a + 1 > last_pre[b] + T_RP) ? a + 1 : last_pre[b] + T_RP;
            e_cmd[0] = 1; e_bank[0] = b; e_addr[0] = r; e_cyc[0] = x; n_exp = 1;
        end else if (exp_bank != b) begin
            tag = "R5 bank miss";
            x = (a + 1 > last_pre[b] + T_RP) ? a + 1 : last_pre[b] + T_RP;
            e_cmd[0] = 1; e_bank[0] = b; e_addr[0] = r; e_cyc[0] = x;
            e_cmd[1] = 4; e_bank[1] = exp_bank; e_addr[1] = 0; e_cyc[1] = x + 1; n_exp = 2;
        end else begin
            tag = "R6 row miss";
            cls_pre_b = a + 1;
            e_cmd[0] = 4; e_bank[0] = b; e_addr[0] = 0; e_cyc[0] = cls_pre_b;
            x = cls_pre_b + T_RP;
            e_cmd[1] = 1; e_bank[1] = b; e_addr[1] = r; e_cyc[1] = x; n_exp = 2;
        end
        if (n_exp == 0) begin
            e_cmd[0] = w ? 3 : 2; e_bank[0] = b; e_addr[0] = c; e_cyc[0] = a + 1;
        end else begin
            e_cmd[n_exp] = w ? 3 : 2; e_bank[n_exp] = b; e_addr[n_exp] = c; e_cyc[n_exp] = x + T_RCD;
        end
        n_exp++;
        @(negedge clk); #1;
        req_valid = 0;
        n_obs = 0;
        for (int k = 0; k < 60 && !done; k++) begin
            if (req_ready) ready_leak = 1;
            if (cmd != 3'd0) begin
                if (n_obs < n_exp) begin
                    check(int'(cmd) == e_cmd[n_obs], {tag, " R2 code"}, int'(cmd), e_cmd[n_obs]);
                    check(int'(cmd_bank) == e_bank[n_obs], {tag, " R2 bank"}, int'(cmd_bank), e_bank[n_obs]);
                    check(int'(cmd_addr) == e_addr[n_obs], {tag, " R2 addr"}, int'(cmd_addr), e_addr[n_obs]);
                    check(cyc == e_cyc[n_obs], {tag, " cycle"}, cyc, e_cyc[n_obs]);
                end
                n_obs++;
                if (cmd == 3'd2 || cmd == 3'd3) done = 1;
            end
            if (!done) begin @(negedge clk); #1; end
        end
        check(done && n_obs == n_exp, {tag, " command count"}, n_obs, n_exp);
        check(!ready_leak, "R1 ready low while busy", int'(ready_leak), 0);
        exp_valid = 1; exp_bank = b; exp_row = r;
        @(negedge clk); #1;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin last_pre[i] = -1000; act_cyc[i] = -1000; bopen[i] = 0; end
        repeat (3) @(negedge clk);
        #1 rst = 0;
        last_ref = cyc;
        @(negedge clk); #1;
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(cmd == 3'd0, "R1 NOP after reset", int'(cmd), 0);
        for (int b1 = 0; b1 < NB; b1++)
            for (int r1 = 0; r1 < 4; r1++)
                for (int b2 = 0; b2 < NB; b2++)
                    for (int r2 = 0; r2 < 4; r2++) begin
                        issue(b1, r1, (b1 * 4 + r1) % 8, bit'((b2 + r2) % 2));
                        issue(b2, r2, (b2 * 3 + r2 + 1) % 8, bit'((b1 + r1) % 2));
                    end
        // idle long enough for refreshes with nothing open
        repeat (2 * REF_PERIOD) @(negedge clk);
        #1 check(cyc - last_ref <= REF_PERIOD, "R9 refresh while idle", cyc - last_ref, REF_PERIOD);
        issue(1, 2, 5, 1'b0);
        finish_run();
    end

endmodule